// File: doc/BRIEF.md
# I2C Master Status and Interrupt Unit

This unit sits beside an I2C master engine and condenses what that engine, its bus monitor and its two-byte transmit and one-level receive queues report into a single 16-bit read-only status word and one interrupt request line. The engine and monitor deliver single-cycle event strobes: start seen, stop seen, byte pushed into the receive queue, transfer finished, NACK after a data byte, NACK after the address byte, and arbitration lost. It also delivers two levels: master busy, and address-with-write already sent. Finally it delivers the transmit queue fill count.

Every status bit is registered, so an event or level presented in cycle N shows in the status word after the clock edge that ends cycle N. Two bits remember state: bus-busy keeps its value between start and stop, and transfer-complete stays set until software clears it. All other flags show the condition seen in the previous cycle and fall back to 0 when that condition is gone. The interrupt request is the OR of each flag ANDed with its enable. The enables are combined with the registered flags without a further register.

Top module: `i2c_mstat_irq`

## Requirements
- R1: Status bit 10 (bus busy) becomes 1 the cycle after a start strobe and 0 the cycle after a stop strobe. If both strobes arrive in the same cycle, start wins. Otherwise the bit holds its value.
- R2: Status bit 9 (receive overflow) is 1 exactly in the cycle after one in which a receive push strobe occurred while the receive-full input was 1, and 0 otherwise.
- R3: Status bit 8 (transfer complete) is set the cycle after a done strobe. It stays set until a cycle with the clear strobe, after which it reads 0. A done strobe in the same cycle as the clear strobe leaves it set.
- R4: Status bit 7 reflects the data-NACK strobe and status bit 4 reflects the address-NACK strobe, each delayed by one cycle. Both feed the interrupt through the single NACK enable.
- R5: Status bit 6 equals the master-busy input of the previous cycle.
- R6: Status bit 5 (arbitration lost) equals the arbitration-lost strobe of the previous cycle.
- R7: Status bit 3 (receive request) equals the receive push strobe of the previous cycle.
- R8: Status bit 2 (transmit request) is 1 only if, in the previous cycle, the address-plus-write input was 1 and the transmit count was 0 or 1.
- R9: Status bits 1:0 encode the previous cycle's transmit count as follows: 0 gives 00, 1 gives 01, 2 or more gives 11. The code 10 never appears.
- R10: Status bits 15:11 always read 0.
- R11: irq = (bit8 & ie_done) | ((bit7|bit4) & ie_nack) | (bit5 & ie_arb) | (bit3 & ie_rxq) | (bit2 & ie_txq). It follows enable changes in the same cycle.
- R12: While reset is asserted, and in the first cycle after it is released, the status word reads 0x0000 and irq reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_start | input | 1 | Start condition seen on the bus |
| ev_stop | input | 1 | Stop condition seen on the bus |
| ev_rx_push | input | 1 | Byte written into the receive queue |
| rx_full | input | 1 | Receive queue already full |
| ev_done | input | 1 | Transfer with the addressed slave finished |
| ev_data_nack | input | 1 | NACK received after a data byte |
| ev_addr_nack | input | 1 | NACK received after the address byte |
| ev_arb_lost | input | 1 | Arbitration lost |
| mst_busy | input | 1 | This master is processing a transaction |
| addr_wr_sent | input | 1 | Address with write direction has been sent |
| tx_count | input | CW | Transmit queue fill count |
| ie_done | input | 1 | Interrupt enable, transfer complete |
| ie_nack | input | 1 | Interrupt enable, both NACK flags |
| ie_arb | input | 1 | Interrupt enable, arbitration lost |
| ie_rxq | input | 1 | Interrupt enable, receive request |
| ie_txq | input | 1 | Interrupt enable, transmit request |
| done_clr | input | 1 | Clear strobe for transfer complete |
| status | output | 16 | Status word |
| irq | output | 1 | Combined interrupt request |

## Verification
The two stored bits are where a wrong internal state can persist:
- A bus-busy or transfer-complete bit with a wrong value stays wrong until the next start, stop, done or clear. Its irq term stays wrong for that whole time.
- A fault in any other flag lasts exactly one cycle and shows the cycle after the stimulus.

For this reason the bench compares every field and irq on every clock, so that a one-cycle error cannot slip past. It drives random strobes with biased densities, so that simultaneous start/stop and done/clear cases, overflows and every transmit count all occur.

// File: rtl/i2c_mstat_irq.sv
module i2c_mstat_irq #(
  parameter int TX_DEPTH = 2,
  localparam int CW = $clog2(TX_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_rx_push,
  input  logic          rx_full,
  input  logic          ev_done,
  input  logic          ev_data_nack,
  input  logic          ev_addr_nack,
  input  logic          ev_arb_lost,
  input  logic          mst_busy,
  input  logic          addr_wr_sent,
  input  logic [CW-1:0] tx_count,
  input  logic          ie_done,
  input  logic          ie_nack,
  input  logic          ie_arb,
  input  logic          ie_rxq,
  input  logic          ie_txq,
  input  logic          done_clr,
  output logic [15:0]   status,
  output logic          irq
);

  logic bus_busy, rx_ovf, xfer_done, data_nack, own_busy, arb_lost, addr_nack, rx_req, tx_req;
  logic [1:0] tx_code;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_busy  <= 1'b0;
      rx_ovf    <= 1'b0;
      xfer_done <= 1'b0;
      data_nack <= 1'b0;
      own_busy  <= 1'b0;
      arb_lost  <= 1'b0;
      addr_nack <= 1'b0;
      rx_req    <= 1'b0;
      tx_req    <= 1'b0;
      tx_code   <= 2'b00;
    end else begin
      if (ev_start)     bus_busy <= 1'b1;
      else if (ev_stop) bus_busy <= 1'b0;
      if (ev_done)       xfer_done <= 1'b1;
      else if (done_clr) xfer_done <= 1'b0;
      rx_ovf    <= ev_rx_push & rx_full;
      data_nack <= ev_data_nack;
      own_busy  <= mst_busy;
      arb_lost  <= ev_arb_lost;
      addr_nack <= ev_addr_nack;
      rx_req    <= ev_rx_push;
      tx_req    <= addr_wr_sent && (tx_count <= CW'(1));
      if (tx_count == '0)                tx_code <= 2'b00;
      else if (tx_count < CW'(TX_DEPTH)) tx_code <= 2'b01;
      else                               tx_code <= 2'b11;
    end
  end

  assign status = {5'b0, bus_busy, rx_ovf, xfer_done, data_nack, own_busy,
                   arb_lost, addr_nack, rx_req, tx_req, tx_code};

  assign irq = (xfer_done & ie_done) | ((data_nack | addr_nack) & ie_nack) |
               (arb_lost & ie_arb) | (rx_req & ie_rxq) | (tx_req & ie_txq);

  assert_busy_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> status[10]);
  assert_busy_clr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_start) |=> !status[10]);
  assert_ovf_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_push && rx_full) |=> status[9]);
  assert_ovf_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_rx_push && rx_full) |=> !status[9]);
  assert_done_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (status[8] && !done_clr) |=> status[8]);
  assert_done_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_clr && !ev_done) |=> !status[8]);
  assert_txq_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_wr_sent |=> !status[2]);
  assert_no_code10_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[1:0] != 2'b10);
  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    status[15:11] == 5'b0);
  assert_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ie_done || ie_nack || ie_arb || ie_rxq || ie_txq) |-> !irq);

endmodule

// File: tb/i2c_mstat_irq_tb_top.sv
module i2c_mstat_irq_tb_top;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_start = 0, ev_stop = 0, ev_rx_push = 0, rx_full = 0, ev_done = 0;
  logic ev_data_nack = 0, ev_addr_nack = 0, ev_arb_lost = 0, mst_busy = 0, addr_wr_sent = 0;
  logic [CW-1:0] tx_count = '0;
  logic ie_done = 1, ie_nack = 1, ie_arb = 1, ie_rxq = 1, ie_txq = 1, done_clr = 0;
  logic [15:0] status;
  logic irq;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  i2c_mstat_irq dut_i (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
    .ev_rx_push(ev_rx_push), .rx_full(rx_full), .ev_done(ev_done),
    .ev_data_nack(ev_data_nack), .ev_addr_nack(ev_addr_nack), .ev_arb_lost(ev_arb_lost),
    .mst_busy(mst_busy), .addr_wr_sent(addr_wr_sent), .tx_count(tx_count),
    .ie_done(ie_done), .ie_nack(ie_nack), .ie_arb(ie_arb), .ie_rxq(ie_rxq),
    .ie_txq(ie_txq), .done_clr(done_clr), .status(status), .irq(irq)
  );

  int m_bus, m_ovf, m_done, m_dn, m_mb, m_arb, m_an, m_rxq, m_txq, m_code;

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pick(int pct);
    return $urandom_range(99) < pct;
  endfunction

  task automatic model_reset();
    m_bus = 0; m_ovf = 0; m_done = 0; m_dn = 0; m_mb = 0;
    m_arb = 0; m_an = 0; m_rxq = 0; m_txq = 0; m_code = 0;
  endtask

  task automatic model_step();
    if (ev_start) m_bus = 1;
    else if (ev_stop) m_bus = 0;
    if (ev_done) m_done = 1;
    else if (done_clr) m_done = 0;
    m_ovf = (ev_rx_push && rx_full) ? 1 : 0;
    m_dn = ev_data_nack;
    m_mb = mst_busy;
    m_arb = ev_arb_lost;
    m_an = ev_addr_nack;
    m_rxq = ev_rx_push;
    m_txq = (addr_wr_sent && tx_count <= 1) ? 1 : 0;
    m_code = (tx_count == 0) ? 0 : (tx_count == 1) ? 1 : 3;
  endtask

  task automatic compare_all(bit in_reset);
    int exp_irq;
    exp_irq = ((m_done & ie_done) | ((m_dn | m_an) & ie_nack) | (m_arb & ie_arb) |
               (m_rxq & ie_rxq) | (m_txq & ie_txq));
    if (in_reset) chk("R12 reset word", status, 0);
    chk("R1 bus busy", status[10], m_bus);
    chk("R2 rx overflow", status[9], m_ovf);
    chk("R3 transfer complete", status[8], m_done);
    chk("R4 data nack", status[7], m_dn);
    chk("R4 addr nack", status[4], m_an);
    chk("R5 master busy", status[6], m_mb);
    chk("R6 arb lost", status[5], m_arb);
    chk("R7 rx request", status[3], m_rxq);
    chk("R8 tx request", status[2], m_txq);
    chk("R9 tx level code", status[1:0], m_code);
    chk("R10 reserved bits", status[15:11], 0);
    chk("R11 irq", irq, exp_irq);
  endtask

  task automatic drive(int phase);
    int ie_pct;
    ie_pct = (phase == 1) ? 0 : 60;
    ev_start     = pick(15);
    ev_stop      = pick(15);
    ev_rx_push   = pick(30);
    rx_full      = pick(40);
    ev_done      = pick(10);
    done_clr     = pick(phase == 2 ? 40 : 8);
    ev_data_nack = pick(10);
    ev_addr_nack = pick(10);
    ev_arb_lost  = pick(10);
    mst_busy     = pick(50);
    addr_wr_sent = pick(60);
    tx_count     = CW'($urandom_range(3));
    ie_done      = pick(ie_pct);
    ie_nack      = pick(ie_pct);
    ie_arb       = pick(ie_pct);
    ie_rxq       = pick(ie_pct);
    ie_txq       = pick(ie_pct);
  endtask

  initial begin
    model_reset();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      compare_all(1'b1);
    end
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      @(negedge clk);
      if (cyc == 0) begin
        model_step();
        chk("R12 first cycle after reset", status, 0);
        compare_all(1'b0);
      end else begin
        model_step();
        compare_all(1'b0);
      end
      drive(cyc < 1000 ? 0 : (cyc < 1500 ? 1 : 2));
    end
    rst_n = 1'b0;
    @(negedge clk);
    model_reset();
    compare_all(1'b1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(20 * 10000);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule